// File: doc/BRIEF.md
# Correlated Double Sampling Pixel Processor

This block sits in a pixel readout pipeline behind the digitizer. Samples arrive one per clock in raster order across a sector of the sensor. For each pixel the block reads the raw sample kept from the previous frame, subtracts it from the fresh sample, and stores the fresh sample in the same memory location. All of this happens in one read-subtract-write pass per clock. The difference is clamped into an 8-bit result. Pixels flagged as hot in a one-bit-per-pixel mask always give a zero result.

The frame memory depth is a parameter. A full sector of 640 by 320 pixels needs `FRAME_PIXELS` set to 204800. The default is kept small so that elaboration stays light. Each output word carries the pixel address, counted from 0 at the frame-start marker. The word appears a fixed two clocks after its input sample. Until one whole frame has been stored after reset there is no reference, so those outputs are flagged invalid. The hot-pixel mask is programmed through a simple address, data and write-enable port while no samples are streaming.

Top module: `cds_pixel_proc`

## Requirements
- R1: For a valid sample, the output value is the new sample minus the raw sample stored for the same pixel address during the previous frame.
- R2: A valid sample clocked in at edge k produces its output word right after edge k+1. A cycle with `in_valid` low never produces `out_valid`.
- R3: The pixel address is 0 on a valid sample with `in_frame_start` high. It rises by one per valid sample. After `FRAME_PIXELS-1` it wraps to 0 even when no frame-start marker is given. `out_addr` carries this address.
- R4: When the new sample is below the stored one, the output value is 0.
- R5: When the difference exceeds 255, the output value is 255. A difference of exactly 255 is passed unchanged.
- R6: A pixel whose mask bit is 1 outputs 0 with `out_valid` still high. Mask bit 0 means a normal pixel.
- R7: Outputs stay invalid until a valid sample at address `FRAME_PIXELS-1` has been stored after reset. Whenever `out_valid` is low, `out_data` is 0.
- R8: A mask write (`mask_we` high) takes effect only in a cycle with `in_valid` low. A write in a cycle with `in_valid` high is ignored.
- R9: Reset clears `out_valid`, `out_data` and the reference-present state. After reset the next frame is treated as the first one.
- R10: Cycles with `in_valid` low do not advance the pixel address and do not change the stored frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A pixel sample is present this cycle |
| in_data | input | PIX_W | Raw digitized pixel sample |
| in_frame_start | input | 1 | Marks the sample as pixel 0 of a frame |
| mask_we | input | 1 | Hot-pixel mask write strobe |
| mask_addr | input | AW | Mask pixel address |
| mask_bit | input | 1 | Mask value, 1 means hot |
| out_valid | output | 1 | Output word is valid |
| out_data | output | OUT_W | Clamped corrected value |
| out_addr | output | AW | Pixel address of the output word |

## Verification
The embedded assertions check on every cycle that hot pixels come out as zero, that negative differences clamp to zero and large ones to full scale, that no output is valid without an input two clocks earlier, that the first frame stays quiet, and that idle cycles leave the address counter alone. Only the bench scenarios can show that the right reference is subtracted per address across frames, and that the address wraps without a marker. They also show that a mask write during streaming is dropped while an idle one is kept, and that a mid-stream reset brings back the first-frame behaviour.

// File: rtl/cds_pkg.sv
package cds_pkg;
  // Pixel count of one full sensor sector (640 x 320).
  localparam int unsigned FULL_SECTOR_PIXELS = 204800;
  localparam int unsigned SYNC_STAGES        = 2;
endpackage

// File: rtl/cds_rst_sync.sv
module cds_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cds_addr_gen.sv
module cds_addr_gen #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_frame_start,
  output logic [AW-1:0] pix_addr,
  output logic          ref_ok
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q, cnt_d;
  logic          ref_q, ref_d;
  logic          cnt_en;

  always_comb begin
    pix_addr = in_frame_start ? '0 : cnt_q;
    cnt_en   = in_valid;
    cnt_d    = (pix_addr == LAST) ? '0 : pix_addr + 1'b1;
    ref_d    = ref_q | (in_valid && (pix_addr == LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      ref_q <= ref_d;
    end
  end

  assign ref_ok = ref_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> cnt_q == $past(cnt_q)); // R10
endmodule

// File: rtl/cds_sync_ram.sv
module cds_sync_ram #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned W     = 12,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Read returns the old content when the same address is written.
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/cds_diff_stage.sv
module cds_diff_stage #(
  parameter int unsigned PIX_W = 12,
  parameter int unsigned OUT_W = 8,
  parameter int unsigned AW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             s_ref_ok,
  input  logic             s_hot,
  input  logic [PIX_W-1:0] s_new,
  input  logic [PIX_W-1:0] s_old,
  input  logic [AW-1:0]    s_addr,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic [AW-1:0]    out_addr
);
  localparam logic [OUT_W-1:0] FULL = '1;

  logic signed [PIX_W:0] diff;
  logic                  over;
  logic [OUT_W-1:0]      sat_val;
  logic                  valid_d;
  logic [OUT_W-1:0]      data_d;

  always_comb diff = $signed({1'b0, s_new}) - $signed({1'b0, s_old});

  generate
    if (PIX_W > OUT_W) begin : g_wide
      always_comb over = |diff[PIX_W-1:OUT_W];
    end else begin : g_narrow
      always_comb over = 1'b0;
    end
  endgenerate

  always_comb begin
    if (diff[PIX_W])  sat_val = '0;
    else if (over)    sat_val = FULL;
    else              sat_val = diff[OUT_W-1:0];
    valid_d = s_valid && s_ref_ok;
    data_d  = (valid_d && !s_hot) ? sat_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= valid_d;
      out_data  <= data_d;
      if (s_valid) out_addr <= s_addr;
    end
  end

  AST_HOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_hot |=> out_data == '0); // R6
  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && (s_old > s_new) |=> out_data == '0); // R4
  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ref_ok && !s_hot && (int'(s_new) - int'(s_old) > int'(FULL))
    |=> out_data == FULL); // R5
endmodule

// File: rtl/cds_pixel_proc.sv
module cds_pixel_proc #(
  parameter int unsigned FRAME_PIXELS = 1024,
  parameter int unsigned PIX_W        = 12,
  parameter int unsigned OUT_W        = 8,
  localparam int unsigned AW          = (FRAME_PIXELS > 1) ? $clog2(FRAME_PIXELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_frame_start,
  input  logic             mask_we,
  input  logic [AW-1:0]    mask_addr,
  input  logic             mask_bit,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic [AW-1:0]    out_addr
);
  logic             rst_i_n;
  logic [AW-1:0]    pix_addr;
  logic             ref_ok;
  logic [PIX_W-1:0] old_q;
  logic             hot_q;
  logic             mask_wr;
  logic             s1_valid, s1_refok;
  logic [PIX_W-1:0] s1_new;
  logic [AW-1:0]    s1_addr;

  cds_rst_sync #(.STAGES(cds_pkg::SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  cds_addr_gen #(.DEPTH(FRAME_PIXELS)) u_addr (
    .clk(clk), .rst_n(rst_i_n), .in_valid(in_valid),
    .in_frame_start(in_frame_start), .pix_addr(pix_addr), .ref_ok(ref_ok));

  cds_sync_ram #(.DEPTH(FRAME_PIXELS), .W(PIX_W)) u_frame (
    .clk(clk), .we(in_valid), .waddr(pix_addr), .wdata(in_data),
    .re(in_valid), .raddr(pix_addr), .rdata(old_q));

  always_comb mask_wr = mask_we && !in_valid;

  cds_sync_ram #(.DEPTH(FRAME_PIXELS), .W(1)) u_mask (
    .clk(clk), .we(mask_wr), .waddr(mask_addr), .wdata(mask_bit),
    .re(in_valid), .raddr(pix_addr), .rdata(hot_q));

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      s1_valid <= 1'b0;
      s1_refok <= 1'b0;
      s1_new   <= '0;
      s1_addr  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_refok <= ref_ok;
      if (in_valid) begin
        s1_new  <= in_data;
        s1_addr <= pix_addr;
      end
    end
  end

  cds_diff_stage #(.PIX_W(PIX_W), .OUT_W(OUT_W), .AW(AW)) u_diff (
    .clk(clk), .rst_n(rst_i_n), .s_valid(s1_valid), .s_ref_ok(s1_refok),
    .s_hot(hot_q), .s_new(s1_new), .s_old(old_q), .s_addr(s1_addr),
    .out_valid(out_valid), .out_data(out_data), .out_addr(out_addr));

  AST_FIRST_FRAME_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ref_ok |=> ##1 !out_valid); // R7
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_valid |-> $past(in_valid, 2)); // R2
endmodule

// File: tb/cds_pixel_proc_test.sv
`timescale 1ns/1ps
module cds_pixel_proc_test;
  localparam int F = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_frame_start, mask_we, mask_bit;
  logic [11:0] in_data;
  logic [AW-1:0] mask_addr, out_addr;
  logic out_valid;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cds_pixel_proc #(.FRAME_PIXELS(F)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_frame_start(in_frame_start), .mask_we(mask_we), .mask_addr(mask_addr),
    .mask_bit(mask_bit), .out_valid(out_valid), .out_data(out_data),
    .out_addr(out_addr));

  // Stimulus table: {frame_start, sample}; frame A then frame B.
  localparam logic [12:0] VEC [32] = '{
    {1'b1,12'd100},{1'b0,12'd200},{1'b0,12'd300},{1'b0,12'd400},
    {1'b0,12'd500},{1'b0,12'd600},{1'b0,12'd700},{1'b0,12'd0},
    {1'b0,12'd800},{1'b0,12'd900},{1'b0,12'd1000},{1'b0,12'd1100},
    {1'b0,12'd1200},{1'b0,12'd1300},{1'b0,12'd1400},{1'b0,12'd1500},
    {1'b1,12'd110},{1'b0,12'd195},{1'b0,12'd600},{1'b0,12'd450},
    {1'b0,12'd500},{1'b0,12'd855},{1'b0,12'd956},{1'b0,12'd4095},
    {1'b0,12'd790},{1'b0,12'd910},{1'b0,12'd1000},{1'b0,12'd1355},
    {1'b0,12'd1455},{1'b0,12'd1300},{1'b0,12'd1401},{1'b0,12'd1500}};

  // Reference model state
  int ref_mem [F];
  bit mask_m [F];
  bit m_refok = 0;
  int m_cnt = 0;
  // Two-deep expectation pipeline
  bit    e_v [2];
  int    e_d [2];
  int    e_a [2];
  string e_t [2];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit s, int d, bit mwe, int ma, bit mb, string tag);
    int a, diff;
    @(negedge clk);
    check({e_t[1], " valid"}, int'(out_valid), int'(e_v[1]));
    check({e_t[1], " data"}, int'(out_data), e_d[1]);
    if (e_v[1]) check({e_t[1], " addr"}, int'(out_addr), e_a[1]);
    e_v[1] = e_v[0]; e_d[1] = e_d[0]; e_a[1] = e_a[0]; e_t[1] = e_t[0];
    in_valid = v; in_frame_start = s; in_data = 12'(d);
    mask_we = mwe; mask_addr = AW'(ma); mask_bit = mb;
    e_v[0] = 0; e_d[0] = 0; e_a[0] = 0; e_t[0] = tag;
    if (mwe && !v) mask_m[ma] = mb;                // R8
    if (v) begin
      a = s ? 0 : m_cnt;
      diff = d - ref_mem[a];
      if (diff < 0) diff = 0;                       // R4
      if (diff > 255) diff = 255;                   // R5
      if (mask_m[a]) diff = 0;                      // R6
      e_v[0] = m_refok; e_a[0] = a; e_d[0] = m_refok ? diff : 0;
      ref_mem[a] = d;
      if (a == F - 1) m_refok = 1;
      m_cnt = (a == F - 1) ? 0 : a + 1;             // R3
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R9 reset valid", int'(out_valid), 0);
    check("R9 reset data", int'(out_data), 0);
    rst_n = 1;
    m_refok = 0; m_cnt = 0;
    for (int i = 0; i < 2; i++) begin e_v[i] = 0; e_d[i] = 0; e_a[i] = 0; e_t[i] = "R9"; end
    repeat (3) step(0, 0, 0, 0, 0, 0, "R9");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    in_valid = 0; in_frame_start = 0; in_data = 0;
    mask_we = 0; mask_addr = 0; mask_bit = 0;
    for (int i = 0; i < F; i++) ref_mem[i] = 0;
    do_reset();
    // Program mask while idle: hot pixels at 3 and 9
    for (int i = 0; i < F; i++) step(0, 0, 0, 1, i, (i == 3 || i == 9), "R8");
    // Table walk: first frame quiet (R7), second frame compared (R1 R2 R3 R4 R5 R6)
    for (int i = 0; i < 32; i++)
      step(1, VEC[i][12], int'(VEC[i][11:0]), 0, 0, 0, (i < 16) ? "R7" : "R1");
    step(0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");
    // Frame C: mask write during streaming ignored (R8), idle gap (R10)
    step(1, 1, 2000, 1, 5, 1, "R8");
    for (int i = 1; i < F; i++) begin
      if (i == 8) begin
        step(0, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, "R10");
      end
      step(1, 0, 2000 + 10 * i, 0, 0, 0, (i == 5) ? "R8" : "R10");
    end
    // Wrap to address 0 without a frame-start marker
    step(1, 0, 2100, 0, 0, 0, "R3");
    step(1, 0, 1900, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, "R3");
    // Idle mask write on pixel 5 takes effect
    step(0, 0, 0, 1, 5, 1, "R8");
    for (int i = 0; i < F; i++) step(1, (i == 0), 3000 + i, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    // Mid-stream reset brings back first-frame quiet
    step(1, 1, 500, 0, 0, 0, "R9");
    step(1, 0, 600, 0, 0, 0, "R9");
    do_reset();
    for (int i = 0; i < 4; i++) step(1, (i == 0), 700 + i, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule